// File: doc/BRIEF.md
# External Interrupt Polarity Conditioner

This block takes three asynchronous external interrupt pins and turns each one into a request that a downstream interrupt controller can take, which means either an active-high level or a rising edge. Each pin passes through a two-flop synchronizer. It is then sampled on one of two sampling strobes. A per-line trigger setting selects level-high, level-low, rising-edge or falling-edge behaviour. Active-low levels and falling edges are inverted so that the output is always active-high or a rising pulse.

Each line has an 8-bit control field with these bits:
- bit 5 is an enable that masks the line's output.
- bit 4 chooses the fast sampling strobe.
- bits 7:6 select the trigger type.
- bit 0 is a status bit.

In edge modes the status bit is a pending latch that software clears by writing one to it. In level modes bit 0 shows the polarity-corrected level. A parameter places the fields in one of two register layouts. In the packed layout all three fields share one register. In the split layout each field has its own register.

Each line is run by a three-state machine:
- ST_LEVEL: the line is in a level mode.
- ST_EDGE_WAIT: the line is in an edge mode with nothing pending.
- ST_EDGE_PEND: an edge has been captured.

The machine takes these transitions:
- TYPE_TO_LEVEL: a write changes the trigger type to a level mode. It can start in any state.
- TYPE_TO_EDGE: a write changes the trigger type to an edge mode. It can start in any state and always ends in ST_EDGE_WAIT.
- EDGE_SEEN: a qualified rising edge takes ST_EDGE_WAIT to ST_EDGE_PEND.
- SW_CLEAR: a write-one to bit 0 with no edge in the same cycle takes ST_EDGE_PEND back to ST_EDGE_WAIT.

Top module: `extirq_cond`

## Requirements
- R1: After reset every control field is zero, so all lines are level-high, disabled and on the base strobe. All irq_out bits are low and every read returns zero.
- R2: The bits of each field behave as follows.
  - Bit 0 is the status bit.
  - Bit 4 selects the sampling strobe.
  - Bit 5 is the enable.
  - Bits 7:6 select the trigger: 00 level high, 01 level low, 10 rising edge, 11 falling edge.
  - Written values of bits 7:1 read back unchanged.
- R3: With SHARED_LAYOUT=0, the fields of lines 0, 1 and 2 sit at addresses 0x000, 0x328 and 0x32C, each in data bits 7:0. A write to any other address changes nothing, and a read of any other address returns zero.
- R4: With SHARED_LAYOUT=1, one register at address 0x000 holds line 0 in bits 23:16, line 1 in bits 15:8 and line 2 in bits 7:0. Bits 31:24 read as zero.
- R5: A pin goes through two synchronizer flops and a sampling flop. With its strobe held high, a pin change reaches irq_out on the third rising clock edge after it is driven.
- R6: A line samples only in cycles where its selected strobe is high. Bit 4 = 0 selects smp_tick_base and bit 4 = 1 selects smp_tick_fast.
- R7: In a level mode, irq_out is a registered copy of enable AND the sampled level, inverted for level low.
- R8: In an edge mode, a qualified rising edge (a falling edge when bits 7:6 = 11) gives a one-cycle irq_out pulse, gated by enable.
- R9: In an edge mode, a detected edge sets bit 0, and bit 0 stays set until a write with bit 0 = 1. Writing 0 to bit 0 has no effect.
- R10: When an edge is detected in the same cycle as a write-one-to-clear, the edge wins and bit 0 remains set.
- R11: In a level mode, bit 0 reads back the polarity-corrected sampled level, and writes to bit 0 are ignored.
- R12: Clearing enable forces irq_out low, but edges are still recorded in bit 0.
- R13: A write that changes bits 7:6 discards any pending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick_base | input | 1 | Base sampling strobe |
| smp_tick_fast | input | 1 | Fast sampling strobe |
| pin_in | input | 3 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| irq_out | output | 3 | Conditioned active-high or rising requests |

## Verification
Edge capture and the software clear of the pending bit can land in the same clock edge. The bench provokes this in a directed step: it raises the pin two cycles ahead of a write-one-to-clear, so that detection and the write meet at one edge. It then expects bit 0 to stay set and irq_out to pulse. The random phase also reaches this collision, and there a cycle-level model of the requirements judges each cycle. The model checks both register layouts in lockstep.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int NLINES     = 3;
    localparam int FIELD_W    = 8;
    localparam int BIT_STAT   = 0;
    localparam int BIT_CLKSEL = 4;
    localparam int BIT_EN     = 5;
    localparam int BIT_TYP_LO = 6;
    localparam int BIT_TYP_HI = 7;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'b00,
        TRIG_LVL_LO = 2'b01,
        TRIG_RISE   = 2'b10,
        TRIG_FALL   = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        ST_LEVEL     = 2'b00,
        ST_EDGE_WAIT = 2'b01,
        ST_EDGE_PEND = 2'b10
    } line_state_e;

    function automatic logic trig_inverts(trig_e t);
        return (t == TRIG_LVL_LO) || (t == TRIG_FALL);
    endfunction

    function automatic logic trig_is_edge(trig_e t);
        return (t == TRIG_RISE) || (t == TRIG_FALL);
    endfunction

endpackage

// File: rtl/extirq_regif.sv
module extirq_regif
    import extirq_pkg::*;
#(
    parameter bit SHARED_LAYOUT = 1'b0,
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 32,
    parameter logic [ADDR_W-1:0] OFS0 = 12'h000,
    parameter logic [ADDR_W-1:0] OFS1 = 12'h328,
    parameter logic [ADDR_W-1:0] OFS2 = 12'h32C
) (
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NLINES-1:0][FIELD_W-1:0] field_rd,
    output logic [DATA_W-1:0]              rd_data,
    output logic [NLINES-1:0]              line_wstb,
    output logic [NLINES-1:0][FIELD_W-1:0] line_wfield
);

    localparam int PACK_W = FIELD_W * NLINES;

    generate
        if (SHARED_LAYOUT) begin : g_shared
            logic wr_hit;
            logic unused_hi;

            assign wr_hit    = wr_en && (wr_addr == OFS0);
            assign unused_hi = ^wr_data[DATA_W-1:PACK_W];

            for (genvar i = 0; i < NLINES; i++) begin : g_ln
                assign line_wstb[i]   = wr_hit;
                assign line_wfield[i] = wr_data[FIELD_W*(NLINES-1-i) +: FIELD_W];
            end

            always_comb begin
                rd_data = '0;
                if (rd_addr == OFS0) begin
                    for (int i = 0; i < NLINES; i++) begin
                        rd_data[FIELD_W*(NLINES-1-i) +: FIELD_W] = field_rd[i];
                    end
                end
            end
        end else begin : g_split
            localparam logic [ADDR_W-1:0] OFS_TAB [NLINES] = '{OFS0, OFS1, OFS2};
            logic unused_hi;

            assign unused_hi = ^wr_data[DATA_W-1:FIELD_W];

            for (genvar i = 0; i < NLINES; i++) begin : g_ln
                assign line_wstb[i]   = wr_en && (wr_addr == OFS_TAB[i]);
                assign line_wfield[i] = wr_data[FIELD_W-1:0];
            end

            always_comb begin
                rd_data = '0;
                for (int i = 0; i < NLINES; i++) begin
                    if (rd_addr == OFS_TAB[i]) begin
                        rd_data[FIELD_W-1:0] = field_rd[i];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_base,
    input  logic               tick_fast,
    input  logic               pin,
    input  logic               wr_stb,
    input  logic [FIELD_W-1:0] wr_field,
    output logic [FIELD_W-1:0] field_rd,
    output logic               irq
);

    logic [FIELD_W-1:1] ctl_q;
    logic               sync1_q;
    logic               sync2_q;
    logic               smp_q;
    line_state_e        st_q;
    line_state_e        st_d;

    trig_e trig;
    logic  tick;
    logic  inv;
    logic  edge_mode;
    logic  en;
    logic  pol_now;
    logic  pol_old;
    logic  rise;
    logic  qual_next;
    logic  type_chg;
    logic  w1c;

    assign trig      = trig_e'(ctl_q[BIT_TYP_HI:BIT_TYP_LO]);
    assign inv       = trig_inverts(trig);
    assign edge_mode = trig_is_edge(trig);
    assign en        = ctl_q[BIT_EN];
    assign tick      = ctl_q[BIT_CLKSEL] ? tick_fast : tick_base;

    assign pol_now   = sync2_q ^ inv;
    assign pol_old   = smp_q ^ inv;
    assign rise      = tick && pol_now && !pol_old;
    assign qual_next = (tick ? sync2_q : smp_q) ^ inv;

    assign type_chg  = wr_stb && (wr_field[BIT_TYP_HI:BIT_TYP_LO] != ctl_q[BIT_TYP_HI:BIT_TYP_LO]);
    assign w1c       = wr_stb && wr_field[BIT_STAT];

    // control field storage (bits 7:1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_stb) begin
            ctl_q <= wr_field[FIELD_W-1:1];
        end
    end

    // synchronizer and sampling flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            smp_q   <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            if (tick) begin
                smp_q <= sync2_q;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (type_chg) begin
            st_d = wr_field[BIT_TYP_HI] ? ST_EDGE_WAIT : ST_LEVEL;
        end else begin
            unique case (st_q)
                ST_LEVEL:     st_d = ST_LEVEL;
                ST_EDGE_WAIT: if (rise) st_d = ST_EDGE_PEND;
                ST_EDGE_PEND: if (w1c && !rise) st_d = ST_EDGE_WAIT;
                default:      st_d = ST_LEVEL;
            endcase
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= en && (edge_mode ? rise : qual_next);
        end
    end

    assign field_rd = {ctl_q, (edge_mode ? (st_q == ST_EDGE_PEND) : pol_old)};

    AST_MASK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq); // R12
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EDGE_PEND && !w1c && !type_chg) |=> (st_q == ST_EDGE_PEND)); // R9
    AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && edge_mode && !type_chg) |=> (st_q == ST_EDGE_PEND)); // R10
    AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !wr_stb) |=> !rise); // R8
    AST_TYPECHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        type_chg |=> (st_q != ST_EDGE_PEND)); // R13
    AST_LVL_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |-> (st_q == ST_LEVEL)); // R11

endmodule

// File: rtl/extirq_cond.sv
module extirq_cond
    import extirq_pkg::*;
#(
    parameter bit SHARED_LAYOUT = 1'b0,
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 32,
    parameter logic [ADDR_W-1:0] OFS0 = 12'h000,
    parameter logic [ADDR_W-1:0] OFS1 = 12'h328,
    parameter logic [ADDR_W-1:0] OFS2 = 12'h32C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick_base,
    input  logic              smp_tick_fast,
    input  logic [2:0]        pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        irq_out
);

    logic [NLINES-1:0]              line_wstb;
    logic [NLINES-1:0][FIELD_W-1:0] line_wfield;
    logic [NLINES-1:0][FIELD_W-1:0] field_rd;

    extirq_regif #(
        .SHARED_LAYOUT (SHARED_LAYOUT),
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .OFS0          (OFS0),
        .OFS1          (OFS1),
        .OFS2          (OFS2)
    ) u_regif (
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .field_rd    (field_rd),
        .rd_data     (rd_data),
        .line_wstb   (line_wstb),
        .line_wfield (line_wfield)
    );

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            extirq_line u_line (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_base (smp_tick_base),
                .tick_fast (smp_tick_fast),
                .pin       (pin_in[i]),
                .wr_stb    (line_wstb[i]),
                .wr_field  (line_wfield[i]),
                .field_rd  (field_rd[i]),
                .irq       (irq_out[i])
            );
        end

        if (!SHARED_LAYOUT) begin : g_split_chk
            AST_SPLIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(line_wstb)); // R3
        end else begin : g_shared_chk
            AST_SHARED_ALL: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr != OFS0) |-> (line_wstb == '0)); // R4
        end
    endgenerate

endmodule

// File: tb/extirq_cond_tb.sv
module extirq_cond_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] OFS [3] = '{12'h000, 12'h328, 12'h32C};
    localparam logic [11:0] BAD_ADDR = 12'h004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_b, tick_f;
    logic [2:0]  pins;
    logic        wr_en;
    logic [11:0] wa_a, wa_b, ra_a, ra_b;
    logic [31:0] wd_a, wd_b, rd_a, rd_b;
    logic [2:0]  irq_a, irq_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    extirq_cond #(.SHARED_LAYOUT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_tick_base(tick_b), .smp_tick_fast(tick_f),
        .pin_in(pins), .wr_en(wr_en), .wr_addr(wa_a), .wr_data(wd_a),
        .rd_addr(ra_a), .rd_data(rd_a), .irq_out(irq_a));

    extirq_cond #(.SHARED_LAYOUT(1'b1)) u_dut_pk (
        .clk(clk), .rst_n(rst_n), .smp_tick_base(tick_b), .smp_tick_fast(tick_f),
        .pin_in(pins), .wr_en(wr_en), .wr_addr(wa_b), .wr_data(wd_b),
        .rd_addr(ra_b), .rd_data(rd_b), .irq_out(irq_b));

    // requirement model state
    logic [7:0] m_ctl [3];
    logic       m_f1 [3];
    logic       m_f2 [3];
    logic       m_smp [3];
    logic       m_irq [3];
    int         m_st [3];   // 0 level, 1 edge idle, 2 edge pending

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [7:0] exp_field(int l);
        logic b0;
        b0 = m_ctl[l][7] ? (m_st[l] == 2) : (m_smp[l] ^ m_ctl[l][6]);
        return {m_ctl[l][7:1], b0};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < 3; l++) begin
            m_ctl[l] = '0; m_f1[l] = 0; m_f2[l] = 0; m_smp[l] = 0; m_irq[l] = 0; m_st[l] = 0;
        end
    endtask

    task automatic step(input logic [2:0] p, input bit t_b, input bit t_f, input int op,
                        input int ln, input logic [7:0] fld, input int rl);
        logic       wstb [3];
        logic [7:0] wf [3];
        logic [31:0] exp_a, exp_b;
        for (int l = 0; l < 3; l++) begin
            wstb[l] = 1'b0;
            wf[l]   = {m_ctl[l][7:1], 1'b0};
        end
        pins = p; tick_b = t_b; tick_f = t_f; wr_en = (op != 0);
        wa_a = '0; wa_b = '0; wd_a = '0; wd_b = '0;
        if (op == 1) begin
            wstb[ln] = 1'b1; wf[ln] = fld;
            wa_a = OFS[ln]; wd_a = {24'h0, fld};
            wa_b = 12'h000; wd_b = {8'h00, wf[0], wf[1], wf[2]};
        end else if (op == 2) begin
            wa_a = BAD_ADDR; wa_b = BAD_ADDR; wd_a = $urandom; wd_b = $urandom;
        end
        ra_a = (rl < 3) ? OFS[rl] : BAD_ADDR;
        ra_b = (rl < 3) ? 12'h000 : BAD_ADDR;
        for (int l = 0; l < 3; l++) begin
            logic tk, inv, rise, qn;
            tk   = m_ctl[l][4] ? t_f : t_b;
            inv  = m_ctl[l][6];
            rise = tk & (m_f2[l] ^ inv) & ~(m_smp[l] ^ inv);
            qn   = (tk ? m_f2[l] : m_smp[l]) ^ inv;
            if (wstb[l] && (wf[l][7:6] != m_ctl[l][7:6])) m_st[l] = wf[l][7] ? 1 : 0;
            else if (m_st[l] == 1 && rise) m_st[l] = 2;
            else if (m_st[l] == 2 && wstb[l] && wf[l][0] && !rise) m_st[l] = 1;
            m_irq[l] = m_ctl[l][5] & (m_ctl[l][7] ? rise : qn);
            if (tk) m_smp[l] = m_f2[l];
            m_f2[l] = m_f1[l];
            m_f1[l] = p[l];
            if (wstb[l]) m_ctl[l] = {wf[l][7:1], 1'b0};
        end
        @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < 3; l++) begin
            chk(irq_a[l] === m_irq[l], m_ctl[l][7] ? "R8 edge irq split" : "R7 level irq split",
                {31'h0, irq_a[l]}, {31'h0, m_irq[l]});
            chk(irq_b[l] === m_irq[l], m_ctl[l][7] ? "R8 edge irq packed" : "R7 level irq packed",
                {31'h0, irq_b[l]}, {31'h0, m_irq[l]});
        end
        exp_a = (rl < 3) ? {24'h0, exp_field(rl)} : 32'h0;
        exp_b = (rl < 3) ? {8'h0, exp_field(0), exp_field(1), exp_field(2)} : 32'h0;
        chk(rd_a === exp_a, "R3 split readback", rd_a, exp_a);
        chk(rd_b === exp_b, "R4 packed readback", rd_b, exp_b);
    endtask

    task automatic idle(input int n, input logic [2:0] p);
        for (int i = 0; i < n; i++) step(p, 1'b1, 1'b1, 0, 0, 8'h00, 0);
    endtask

    task automatic wr(input int ln, input logic [7:0] f, input logic [2:0] p);
        step(p, 1'b1, 1'b1, 1, ln, f, ln);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] pv;
        void'($urandom(32'h5EED_1234));
        pins = '0; tick_b = 0; tick_f = 0; wr_en = 0;
        wa_a = '0; wa_b = '0; wd_a = '0; wd_b = '0; ra_a = '0; ra_b = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(irq_a === 3'b000 && irq_b === 3'b000, "R1 irq after reset", {29'h0, irq_a}, 32'h0);
        chk(rd_a === 32'h0, "R1 split read after reset", rd_a, 32'h0);
        chk(rd_b === 32'h0, "R1 packed read after reset", rd_b, 32'h0);

        pv = 3'b000;
        // R2: bits 7:1 stored as written
        wr(1, 8'h1E, pv);
        chk(rd_a === 32'h1E, "R2 field store", rd_a, 32'h1E);

        // R8 / R9 / R5: rising edge on line 0
        wr(0, 8'hA0, pv);
        idle(2, pv);
        pv[0] = 1'b1;
        idle(3, pv);
        chk(irq_a[0] === 1'b1, "R5 latency to pulse", {31'h0, irq_a[0]}, 32'h1);
        chk(rd_a[7:0] === 8'hA1, "R9 pending set", rd_a, 32'hA1);
        idle(1, pv);
        chk(irq_a[0] === 1'b0, "R8 single pulse", {31'h0, irq_a[0]}, 32'h0);
        wr(0, 8'hA0, pv);
        chk(rd_a[0] === 1'b1, "R9 write zero keeps pending", rd_a, 32'hA1);
        wr(0, 8'hA1, pv);
        chk(rd_a[0] === 1'b0, "R9 write one clears", rd_a, 32'hA0);

        // R10: detection and clear in the same cycle
        pv[0] = 1'b0;
        idle(4, pv);
        pv[0] = 1'b1;
        idle(2, pv);
        wr(0, 8'hA1, pv);
        chk(rd_a[0] === 1'b1, "R10 edge beats clear", rd_a, 32'hA1);
        chk(irq_a[0] === 1'b1, "R10 pulse on collision", {31'h0, irq_a[0]}, 32'h1);

        // R13: type change discards pending
        wr(0, 8'hE0, pv);
        chk(rd_a[7:0] === 8'hE0, "R13 type change clears", rd_a, 32'hE0);

        // R12: disabled falling edge still latches
        wr(0, 8'hC0, pv);
        pv[0] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            idle(1, pv);
            chk(irq_a[0] === 1'b0, "R12 masked output", {31'h0, irq_a[0]}, 32'h0);
        end
        chk(rd_a[0] === 1'b1, "R12 pending while masked", rd_a, 32'hC1);

        // R11 / R7: level low
        wr(0, 8'h61, pv);
        idle(3, pv);
        chk(irq_a[0] === 1'b1, "R7 level low asserted", {31'h0, irq_a[0]}, 32'h1);
        chk(rd_a[7:0] === 8'h61, "R11 level readback", rd_a, 32'h61);
        pv[0] = 1'b1;
        idle(4, pv);
        chk(irq_a[0] === 1'b0, "R7 level low released", {31'h0, irq_a[0]}, 32'h0);
        chk(rd_a[7:0] === 8'h60, "R11 level readback low", rd_a, 32'h60);
        wr(0, 8'h61, pv);
        chk(rd_a[0] === 1'b0, "R11 write to status ignored", rd_a, 32'h60);

        // R6: strobe select on line 2
        wr(2, 8'h30, pv);
        pv[2] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step(pv, 1'b1, 1'b0, 0, 0, 8'h00, 2);
            chk(irq_a[2] === 1'b0, "R6 no sample without fast strobe", {31'h0, irq_a[2]}, 32'h0);
        end
        step(pv, 1'b1, 1'b1, 0, 0, 8'h00, 2);
        chk(irq_a[2] === 1'b1, "R6 sample on fast strobe", {31'h0, irq_a[2]}, 32'h1);

        // R3: unmapped address
        step(pv, 1'b1, 1'b1, 2, 0, 8'h00, 3);
        chk(rd_a === 32'h0, "R3 unmapped read", rd_a, 32'h0);
        step(pv, 1'b1, 1'b1, 0, 0, 8'h00, 1);
        chk(rd_a === 32'h1E, "R3 unmapped write ignored", rd_a, 32'h1E);

        // R4: packed layout order
        chk(rd_b === 32'h00601E31, "R4 packed order", rd_b, 32'h00601E31);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            int op, ln, rl, sel;
            logic [7:0] f;
            logic tb_v, tf_v;
            for (int b = 0; b < 3; b++) if (($urandom % 4) == 0) pv[b] = ~pv[b];
            sel  = $urandom % 10;
            op   = (sel < 7) ? 0 : ((sel < 9) ? 1 : 2);
            ln   = $urandom % 3;
            f    = 8'($urandom);
            if (($urandom % 4) != 0) f[5] = 1'b1;
            if (($urandom % 3) != 0) f[7:6] = m_ctl[ln][7:6];
            rl   = $urandom % 4;
            tb_v = (($urandom % 10) < 7);
            tf_v = (($urandom % 10) < 7);
            step(pv, tb_v, tf_v, op, ln, f, rl);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule